// File: doc/BRIEF.md
# Exception State Register Block

This block holds the exception state of a 32-bit processor. The processor's control reads and updates four registers here. A status word carries a per-level interrupt mask and a three-entry stack of (mode, interrupt-enable) pairs. A cause word carries sticky pending-interrupt bits and a 4-bit exception code. An exception-PC register keeps the address of the faulting instruction, and a bad-address register keeps the memory address of a faulting reference.

When the pipeline raises an exception request, the block does three things in one clock edge. It pushes the mode/enable stack, forces the current pair to kernel mode with interrupts off, and writes the code, the faulting PC and, for address errors, the faulting address. A return strobe pops the stack. Hardware interrupt lines set pending bits, and only a per-level acknowledge clears them. The interrupt request output combines the pending bits with the mask and the current enable bit. Software reads and writes the registers through a small select/data port.

Top module: `exc_state_regs`

## Requirements
- R1: After reset, status, cause, exception PC and bad address all read zero, and the interrupt request is low.
- R2: Status layout: the mask is in bits 15:8. The stack is in bits 5:0: old in 5:4, previous in 3:2, current in 1:0. In each pair the upper bit is mode (0 kernel, 1 user) and the lower bit is interrupt enable. A software write with select 0 loads only bits 15:8 and 5:0, and all other status bits read 0.
- R3: On an exception request, previous moves to old and current moves to previous, and current becomes 00. The mask is unchanged.
- R4: A return strobe without an exception request moves previous to current and old to previous, and old keeps its value.
- R5: On an exception request, the exception PC takes the faulting PC and cause bits 5:2 take the 4-bit code. Codes in use: 0 interrupt, 4 load/fetch address error, 5 store address error, 6 instruction bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 12 overflow.
- R6: The bad-address register takes the faulting address only on an exception with code 4 or 5. Other codes leave it unchanged.
- R7: Cause bit 10+i is set in the cycle after hardware line i is high. It stays set, whatever the enable or mask state, until a cycle in which acknowledge bit i is high and line i is low.
- R8: The interrupt request is high exactly when current enable (status bit 0) is 1 and some cause bit in 15:10 is set whose status bit of the same position is set.
- R9: An exception request drops a simultaneous software write and return strobe. A return strobe drops a simultaneous software write to status. A software write with select 2 loads the exception PC, and with select 3 loads the bad address.
- R10: The read port returns status, cause, exception PC or bad address for select 0, 1, 2 or 3, combinationally from the current register values.
- R11: A software write with select 1 leaves the cause register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 1 | Exception entry request |
| excCode | input | 4 | Exception code |
| excPc | input | 32 | Address of the faulting instruction |
| excAddr | input | 32 | Faulting memory address |
| rfeStrobe | input | 1 | Return-from-exception strobe |
| hwIrq | input | 6 | Hardware interrupt lines |
| pendAck | input | 6 | Per-level pending acknowledge |
| swWe | input | 1 | Software write enable |
| swSel | input | 2 | Software register select |
| swWdata | input | 32 | Software write data |
| swRdata | output | 32 | Software read data |
| statusOut | output | 32 | Status register |
| causeOut | output | 32 | Cause register |
| epcOut | output | 32 | Exception PC register |
| badAddrOut | output | 32 | Bad address register |
| irqReq | output | 1 | Interrupt request |

## Verification
The stack is pushed twice after a status write that seeds distinct pairs, and then popped twice. This shows that old is kept on pop and shifted on push, and that a wrong shift direction cannot hide. The exception code is swept over every listed value, so that only address-error codes move the bad address. Interrupt lines are pulsed while enable and mask are off, then acknowledged with and without the line still high, which separates sticky capture from level following. Collisions of exception, return and software write in one cycle expose the priority order.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int DATA_W   = 32;
  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 2;
  localparam int MASK_LSB = 8;
  localparam int MASK_W   = 8;
  localparam int NUM_IRQ  = 6;
  localparam int PEND_LSB = 10;
  localparam int STACK_W  = 6;
  localparam int SEL_W    = 2;

  localparam logic [CODE_W-1:0] CODE_ADDR_LOAD  = 4'd4;
  localparam logic [CODE_W-1:0] CODE_ADDR_STORE = 4'd5;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_BAD    = 2'd3
  } regSel_e;

  typedef struct packed {
    logic enter;
    logic pop;
    logic ldStatus;
    logic ldEpc;
    logic ldBad;
    logic capBad;
  } ctlStrobes_t;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic              rfeStrobe,
  input  logic              swWe,
  input  logic [SEL_W-1:0]  swSel,
  output ctlStrobes_t       strobes
);
  logic isAddrErr;

  always_comb begin
    isAddrErr = (excCode == CODE_ADDR_LOAD) || (excCode == CODE_ADDR_STORE);
    strobes.enter    = excReq;
    strobes.pop      = rfeStrobe && !excReq;
    strobes.ldStatus = swWe && !excReq && !rfeStrobe && (swSel == SEL_STATUS);
    strobes.ldEpc    = swWe && !excReq && (swSel == SEL_EPC);
    strobes.ldBad    = swWe && !excReq && (swSel == SEL_BAD);
    strobes.capBad   = excReq && isAddrErr;
  end
endmodule

// File: rtl/exc_dp.sv
module exc_dp
  import exc_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int NIRQ = NUM_IRQ
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [CODE_W-1:0] excCode,
  input  logic [W-1:0]      excPc,
  input  logic [W-1:0]      excAddr,
  input  logic [NIRQ-1:0]   hwIrq,
  input  logic [NIRQ-1:0]   pendAck,
  input  logic [SEL_W-1:0]  swSel,
  input  logic [W-1:0]      swWdata,
  output logic [W-1:0]      swRdata,
  output logic [W-1:0]      statusOut,
  output logic [W-1:0]      causeOut,
  output logic [W-1:0]      epcOut,
  output logic [W-1:0]      badAddrOut,
  output logic              irqReq
);
  localparam int PAIR_W = 2;

  logic [MASK_W-1:0]  maskQ;
  logic [STACK_W-1:0] stackQ;
  logic [CODE_W-1:0]  codeQ;
  logic [NIRQ-1:0]    pendQ;
  logic [W-1:0]       epcQ;
  logic [W-1:0]       badQ;
  logic [NIRQ-1:0]    maskForPend;

  // mode/enable stack and mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      stackQ <= '0;
    end else if (strobes.enter) begin
      stackQ <= {stackQ[STACK_W-PAIR_W-1:0], {PAIR_W{1'b0}}};
    end else if (strobes.pop) begin
      stackQ[STACK_W-PAIR_W-1:0] <= stackQ[STACK_W-1:PAIR_W];
    end else if (strobes.ldStatus) begin
      maskQ  <= swWdata[MASK_LSB +: MASK_W];
      stackQ <= swWdata[STACK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              codeQ <= '0;
    else if (strobes.enter) codeQ <= excCode;
  end

  // sticky pending bits, one per level
  for (genvar i = 0; i < NIRQ; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN)         pendQ[i] <= 1'b0;
      else if (hwIrq[i]) pendQ[i] <= 1'b1;
      else if (pendAck[i]) pendQ[i] <= 1'b0;
    end
    assign maskForPend[i] = maskQ[PEND_LSB - MASK_LSB + i];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              epcQ <= '0;
    else if (strobes.enter) epcQ <= excPc;
    else if (strobes.ldEpc) epcQ <= swWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               badQ <= '0;
    else if (strobes.capBad) badQ <= excAddr;
    else if (strobes.ldBad)  badQ <= swWdata;
  end

  always_comb begin
    statusOut = '0;
    statusOut[MASK_LSB +: MASK_W] = maskQ;
    statusOut[STACK_W-1:0]        = stackQ;
    causeOut = '0;
    causeOut[PEND_LSB +: NIRQ]    = pendQ;
    causeOut[CODE_LSB +: CODE_W]  = codeQ;
    epcOut     = epcQ;
    badAddrOut = badQ;
    irqReq     = stackQ[0] && |(pendQ & maskForPend);
    unique case (swSel)
      SEL_STATUS: swRdata = statusOut;
      SEL_CAUSE:  swRdata = causeOut;
      SEL_EPC:    swRdata = epcQ;
      default:    swRdata = badQ;
    endcase
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic [DATA_W-1:0] excPc,
  input  logic [DATA_W-1:0] excAddr,
  input  logic              rfeStrobe,
  input  logic [NUM_IRQ-1:0] hwIrq,
  input  logic [NUM_IRQ-1:0] pendAck,
  input  logic              swWe,
  input  logic [SEL_W-1:0]  swSel,
  input  logic [DATA_W-1:0] swWdata,
  output logic [DATA_W-1:0] swRdata,
  output logic [DATA_W-1:0] statusOut,
  output logic [DATA_W-1:0] causeOut,
  output logic [DATA_W-1:0] epcOut,
  output logic [DATA_W-1:0] badAddrOut,
  output logic              irqReq
);
  ctlStrobes_t strobes;

  exc_ctrl u_ctrl (
    .excReq(excReq), .excCode(excCode), .rfeStrobe(rfeStrobe),
    .swWe(swWe), .swSel(swSel), .strobes(strobes)
  );

  exc_dp #(.W(DATA_W), .NIRQ(NUM_IRQ)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .excCode(excCode),
    .excPc(excPc), .excAddr(excAddr), .hwIrq(hwIrq), .pendAck(pendAck),
    .swSel(swSel), .swWdata(swWdata), .swRdata(swRdata),
    .statusOut(statusOut), .causeOut(causeOut), .epcOut(epcOut),
    .badAddrOut(badAddrOut), .irqReq(irqReq)
  );
endmodule

// File: rtl/exc_state_regs_chk.sv
module exc_state_regs_chk
  import exc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              excReq,
  input logic [CODE_W-1:0] excCode,
  input logic [DATA_W-1:0] excPc,
  input logic              rfeStrobe,
  input logic [NUM_IRQ-1:0] hwIrq,
  input logic [NUM_IRQ-1:0] pendAck,
  input logic [DATA_W-1:0] statusOut,
  input logic [DATA_W-1:0] causeOut,
  input logic [DATA_W-1:0] epcOut,
  input logic              irqReq
);
  a_r3_enter_kernel: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> statusOut[1:0] == 2'b00);

  a_r3_push_stack: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (statusOut[3:2] == $past(statusOut[1:0])) &&
               (statusOut[5:4] == $past(statusOut[3:2])) &&
               $stable(statusOut[15:8]));

  a_r4_pop_stack: assert property (@(posedge clk) disable iff (!rstN)
    (rfeStrobe && !excReq) |=> (statusOut[1:0] == $past(statusOut[3:2])) &&
                               (statusOut[3:2] == $past(statusOut[5:4])) &&
                               $stable(statusOut[5:4]));

  a_r5_epc_code: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (epcOut == $past(excPc)) && (causeOut[5:2] == $past(excCode)));

  a_r7_pending_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((causeOut[15:10] & $past(causeOut[15:10] & ~pendAck)) ==
              $past(causeOut[15:10] & ~pendAck)) &&
             ((causeOut[15:10] & $past(hwIrq)) == $past(hwIrq)));

  a_r8_irq_req: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (statusOut[0] && |(causeOut[15:10] & statusOut[15:10])));
endmodule

bind exc_state_regs exc_state_regs_chk u_chk (.*);

// File: tb/tb_exc_state_regs.sv
module tb_exc_state_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [3:0]  excCode = '0;
  logic [31:0] excPc = '0;
  logic [31:0] excAddr = '0;
  logic        rfeStrobe = 1'b0;
  logic [5:0]  hwIrq = '0;
  logic [5:0]  pendAck = '0;
  logic        swWe = 1'b0;
  logic [1:0]  swSel = '0;
  logic [31:0] swWdata = '0;
  logic [31:0] swRdata, statusOut, causeOut, epcOut, badAddrOut;
  logic        irqReq;

  exc_state_regs dut (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] mStatus = '0, mEpc = '0, mBad = '0;
  logic [5:0]  mPend = '0;
  logic [3:0]  mCode = '0;

  function automatic logic [31:0] mCause();
    return {16'd0, mPend, 4'd0, mCode, 2'd0};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    logic [31:0] rd;
    logic expIrq;
    chk(tag, "status", statusOut, mStatus);
    chk(tag, "cause", causeOut, mCause());
    chk(tag, "epc", epcOut, mEpc);
    chk(tag, "badaddr", badAddrOut, mBad);
    expIrq = mStatus[0] && ((mPend & mStatus[15:10]) != 0);
    chk({tag, "/R8"}, "irq", {31'd0, irqReq}, {31'd0, expIrq});
    case (swSel)
      2'd0: rd = mStatus;
      2'd1: rd = mCause();
      2'd2: rd = mEpc;
      default: rd = mBad;
    endcase
    chk({tag, "/R10"}, "rdata", swRdata, rd);
  endtask

  task automatic modelStep();
    if (excReq) begin
      mStatus[5:0] = {mStatus[3:0], 2'b00};
      mCode = excCode;
      mEpc = excPc;
      if (excCode == 4'd4 || excCode == 4'd5) mBad = excAddr;
    end else begin
      if (rfeStrobe) mStatus[3:0] = mStatus[5:2];
      else if (swWe && swSel == 2'd0) mStatus = swWdata & 32'h0000_FF3F;
      if (swWe && swSel == 2'd2) mEpc = swWdata;
      if (swWe && swSel == 2'd3) mBad = swWdata;
    end
    mPend = (mPend & ~pendAck) | hwIrq;
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    modelStep();
    #2;
    compareAll(tag);
    excReq = 1'b0; rfeStrobe = 1'b0; swWe = 1'b0;
    pendAck = '0; hwIrq = '0;
  endtask

  task automatic swWrite(logic [1:0] sel, logic [31:0] d, string tag);
    swWe = 1'b1; swSel = sel; swWdata = d;
    tick(tag);
  endtask

  task automatic raise(logic [3:0] code, logic [31:0] pc, logic [31:0] addr, string tag);
    excReq = 1'b1; excCode = code; excPc = pc; excAddr = addr;
    tick(tag);
  endtask

  function automatic string finalLine();
    return $sformatf("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endfunction

  initial begin
    #(10 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("%s", finalLine());
      $finish;
    end
  end

  initial begin
    logic [3:0] codes [9];
    codes = '{4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd12};
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state, all selects
    for (int s = 0; s < 4; s++) begin
      swSel = s[1:0];
      #1 compareAll("R1");
    end
    @(negedge clk);
    rstN = 1'b1;
    tick("R1");

    // R2: status write keeps only mask and stack
    swWrite(2'd0, 32'hFFFF_FFFF, "R2");
    swWrite(2'd0, 32'h0000_0000, "R2");
    // R11: cause write ignored
    hwIrq = 6'b000001;
    tick("R7");
    swWrite(2'd1, 32'hFFFF_FFFF, "R11");
    pendAck = 6'b000001;
    tick("R7");
    // R9/R10: epc and bad address writes, read back
    swWrite(2'd2, 32'h1234_5678, "R9");
    swWrite(2'd3, 32'h9ABC_DEF0, "R9");
    for (int s = 0; s < 4; s++) begin swSel = s[1:0]; tick("R10"); end

    // R3: seed pairs old=10 prev=01 cur=11, then push twice
    swWrite(2'd0, 32'h0000_AA27, "R2");
    raise(4'd12, 32'h0000_0400, 32'hDEAD_0000, "R3");
    raise(4'd8, 32'h0000_0800, 32'hDEAD_0004, "R3");
    // R4: pop twice
    rfeStrobe = 1'b1; tick("R4");
    rfeStrobe = 1'b1; tick("R4");

    // R5/R6: every code
    foreach (codes[k]) begin
      raise(codes[k], 32'h4000_0000 + k * 4, 32'h7000_0100 + k * 8, "R5/R6");
    end

    // R7: pending sticky while disabled, set wins over ack
    swWrite(2'd0, 32'h0000_0000, "R7");
    hwIrq = 6'b101010; tick("R7");
    tick("R7");
    pendAck = 6'b000010; tick("R7");
    hwIrq = 6'b100000; pendAck = 6'b100000; tick("R7");
    hwIrq = 6'b010101; tick("R7");

    // R8: enable and mask combinations
    swWrite(2'd0, 32'h0000_0001, "R8");
    swWrite(2'd0, 32'h0000_0400, "R8");
    swWrite(2'd0, 32'h0000_0401, "R8");
    swWrite(2'd0, 32'h0000_8001, "R8");
    pendAck = 6'b111111; tick("R8");

    // R9: collisions
    swWrite(2'd0, 32'h0000_FF15, "R9");
    excReq = 1'b1; excCode = 4'd9; excPc = 32'hCAFE_0000;
    swWe = 1'b1; swSel = 2'd0; swWdata = 32'h0000_003F; tick("R9");
    excReq = 1'b1; excCode = 4'd5; excPc = 32'hCAFE_0010; excAddr = 32'h0BAD_0BAD;
    swWe = 1'b1; swSel = 2'd3; swWdata = 32'h1111_1111; tick("R9");
    excReq = 1'b1; excCode = 4'd7; excPc = 32'hCAFE_0020;
    rfeStrobe = 1'b1; tick("R9");
    rfeStrobe = 1'b1; swWe = 1'b1; swSel = 2'd0; swWdata = 32'h0000_FF00; tick("R9");
    rfeStrobe = 1'b1; swWe = 1'b1; swSel = 2'd2; swWdata = 32'h2222_2222; tick("R9");
    tick("R1");

    done = 1'b1;
    $display("%s", finalLine());
    $finish;
  end
endmodule